// File: doc/BRIEF.md
# Host Command Byte-Stream Decoder

This block turns the byte stream that a host sends over a serial link into actions on three internal resources: a two-wire bus transfer sequencer, a small register file and an eight-bit pin port. Every command starts with a single printable opcode byte. The opcode is followed by arguments whose layout depends on the opcode, and a terminator byte ends the command. Bytes that the host must get back are placed into a transmit queue, which feeds the serial transmitter. These are register contents, pin levels and data read from the bus.

The receiver, the transmitter and the bus sequencer sit outside the block. Each one is seen as a byte-wide valid/ready channel. The decoder applies back-pressure to the receiver whenever the destination of the current byte cannot take it. It also drops a half-received command after a programmable stretch of host silence. Power-down is requested only after a guarded four-byte key. After reset, a two-byte greeting is queued before any host byte is accepted.

Top module: `cmd_frame_parser`

## Requirements
- R1: After reset, 0x4F and then 0x4B appear on `tx_data`. `rx_ready` stays low until both bytes are queued.
- R2: In opcode position, any byte other than 0x53, 0x52, 0x57, 0x49, 0x4F or 0x5A (0x50 included) is consumed and has no effect.
- R3: A bus write frame is 0x53, then an address byte with bit 0 = 0, then a count N, then N data bytes, then 0x50. It issues requests with `bus_req_op` = 0 (start, arg = address), then N requests with op 1 (write, arg = data), then one request with op 3 (stop). A count of 0 goes straight to waiting for the terminator.
- R4: A bus read frame is 0x53, then an address byte with bit 0 = 1, then a count, then 0x50. It issues op 0 with the address, then op 2 (read, arg = count), then op 3. No data bytes are expected.
- R5: A 0x53 that arrives where the terminator is expected chains a repeated start. The next address byte issues op 0 again, and no op 3 comes in between. Any other byte in that position except 0x50 is ignored.
- R6: Bytes offered on `bus_rd_data` are queued for transmission in arrival order. They take priority over bytes that the decoder itself returns.
- R7: A register write frame is 0x57, then pairs of (address, data), then 0x50. Each data byte pulses `reg_we` with the stored address. An address of 0x50 cannot be written, because 0x50 in that position ends the frame.
- R8: A register read frame is 0x52, then addresses, then 0x50. Each address pulses `reg_re` and queues `reg_rdata` in order.
- R9: 0x4F, a data byte, then 0x50 pulses `pin_we` with that data when the 0x50 arrives. Any other third byte drops the command and produces no write.
- R10: 0x49 followed by 0x50 queues one byte holding `pin_in`. Any other second byte drops the command.
- R11: The exact sequence 0x5A, 0x5A, 0xA5, 0x50 gives a one-cycle `sleep_req` pulse. Any mismatching byte is consumed, and the decoder returns to opcode wait without a pulse.
- R12: Inside a command, GAP_LIMIT clock cycles without an accepted byte drop the partial command. The next byte is then taken as an opcode.
- R13: The transmit queue holds TXQ_DEPTH bytes. When it is full, a byte that would add to it is held off with `rx_ready` low, and no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Decoder takes the byte this cycle |
| tx_valid | output | 1 | Queue has a byte for the transmitter |
| tx_data | output | 8 | Byte at the head of the queue |
| tx_ready | input | 1 | Transmitter takes the head byte |
| bus_req_valid | output | 1 | Request to the bus sequencer |
| bus_req_ready | input | 1 | Sequencer takes the request |
| bus_req_op | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| bus_req_arg | output | 8 | Address, data or count |
| bus_rd_valid | input | 1 | Byte read from the bus |
| bus_rd_data | input | 8 | Read byte |
| bus_rd_ready | output | 1 | Queue has room for the read byte |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid in the same cycle as `reg_re` |
| pin_we | output | 1 | Pin port write strobe |
| pin_wdata | output | 8 | Pin port output value |
| pin_in | input | 8 | Pin levels |
| sleep_req | output | 1 | Power-down request pulse |

## Verification
The bench builds the block with GAP_LIMIT = 64 and the default queue depth of 16. With these values the silence timeout fires after a hundred-cycle pause, while a forty-cycle pause still lets the command complete. Holding the transmitter off during a sixteen-address register read fills the queue, so the seventeenth address shows the back-pressure. The bus sequencer and the register file are modelled in the bench. Every request and strobe is logged and compared with the expected sequence for each frame type.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
    localparam logic [7:0] OPC_START  = 8'h53;
    localparam logic [7:0] OPC_END    = 8'h50;
    localparam logic [7:0] OPC_RREAD  = 8'h52;
    localparam logic [7:0] OPC_RWRITE = 8'h57;
    localparam logic [7:0] OPC_PIN_RD = 8'h49;
    localparam logic [7:0] OPC_PIN_WR = 8'h4F;
    localparam logic [7:0] OPC_SLEEP  = 8'h5A;
    localparam logic [7:0] KEY_A      = 8'h5A;
    localparam logic [7:0] KEY_B      = 8'hA5;
    localparam logic [7:0] HELLO_0    = 8'h4F;
    localparam logic [7:0] HELLO_1    = 8'h4B;

    typedef enum logic [1:0] {
        BUS_START = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2,
        BUS_STOP  = 2'd3
    } bus_op_e;

    typedef struct packed {
        bus_op_e    op;
        logic [7:0] arg;
    } bus_req_t;

    typedef enum logic [3:0] {
        ST_HELLO0, ST_HELLO1, ST_OPC, ST_ADR, ST_CNT, ST_WDATA, ST_TAIL,
        ST_RREG, ST_WREG, ST_WVAL, ST_PVAL, ST_PEND, ST_IEND,
        ST_KEY1, ST_KEY2, ST_ZEND
    } pstate_e;

    function automatic logic in_command(input pstate_e s);
        return !(s == ST_HELLO0 || s == ST_HELLO1 || s == ST_OPC);
    endfunction
endpackage

// File: rtl/cfp_txq.sv
module cfp_txq #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] pdata,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] qdata,
    output logic         nonempty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full     = (cnt == (AW+1)'(DEPTH));
    assign nonempty = (cnt != '0);
    assign qdata    = mem[rp];
    assign do_push  = push && !full;
    assign do_pop   = pop && nonempty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= pdata;
    end
endmodule

// File: rtl/cfp_gap_timer.sv
module cfp_gap_timer #(
    parameter int LIMIT = 4829000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expire = active && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || kick || !active || expire) cnt <= '0;
        else                                  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfp_decoder.sv
module cfp_decoder
    import cfp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       req_valid,
    output bus_req_t   req,
    input  logic       req_ready,
    output logic       reg_we,
    output logic       reg_re,
    output logic [7:0] reg_addr,
    input  logic [7:0] reg_rdata,
    output logic       pin_we,
    output logic [7:0] pin_wdata,
    input  logic [7:0] pin_in,
    output logic       sleep_req,
    output logic       push_valid,
    output logic [7:0] push_data,
    input  logic       push_ready,
    input  logic       expire,
    output logic       active,
    output logic       accept
);
    pstate_e    state, nxt;
    logic [7:0] hold, left;
    logic       is_end;

    assign is_end    = (rx_data == OPC_END);
    assign accept    = rx_valid && rx_ready;
    assign active    = in_command(state);
    assign reg_addr  = (state == ST_RREG) ? rx_data : hold;
    assign pin_wdata = hold;

    always_comb begin
        rx_ready   = 1'b0;
        req_valid  = 1'b0;
        req        = '{op: BUS_START, arg: rx_data};
        reg_we     = 1'b0;
        reg_re     = 1'b0;
        pin_we     = 1'b0;
        sleep_req  = 1'b0;
        push_valid = 1'b0;
        push_data  = HELLO_0;
        nxt        = state;
        case (state)
            ST_HELLO0: begin
                push_valid = 1'b1;
                if (push_ready) nxt = ST_HELLO1;
            end
            ST_HELLO1: begin
                push_valid = 1'b1;
                push_data  = HELLO_1;
                if (push_ready) nxt = ST_OPC;
            end
            ST_OPC: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    case (rx_data)
                        OPC_START:  nxt = ST_ADR;
                        OPC_RREAD:  nxt = ST_RREG;
                        OPC_RWRITE: nxt = ST_WREG;
                        OPC_PIN_RD: nxt = ST_IEND;
                        OPC_PIN_WR: nxt = ST_PVAL;
                        OPC_SLEEP:  nxt = ST_KEY1;
                        default:    nxt = ST_OPC;
                    endcase
                end
            end
            ST_ADR: begin
                req_valid = rx_valid;
                rx_ready  = req_ready;
                if (accept) nxt = ST_CNT;
            end
            ST_CNT: begin
                if (hold[0]) begin
                    req_valid = rx_valid;
                    req.op    = BUS_READ;
                    rx_ready  = req_ready;
                    if (accept) nxt = ST_TAIL;
                end else begin
                    rx_ready = 1'b1;
                    if (accept) nxt = (rx_data == 8'd0) ? ST_TAIL : ST_WDATA;
                end
            end
            ST_WDATA: begin
                req_valid = rx_valid;
                req.op    = BUS_WRITE;
                rx_ready  = req_ready;
                if (accept && left == 8'd1) nxt = ST_TAIL;
            end
            ST_TAIL: begin
                if (is_end) begin
                    req_valid = rx_valid;
                    req.op    = BUS_STOP;
                    rx_ready  = req_ready;
                    if (accept) nxt = ST_OPC;
                end else begin
                    rx_ready = 1'b1;
                    if (accept && rx_data == OPC_START) nxt = ST_ADR;
                end
            end
            ST_RREG: begin
                if (is_end) begin
                    rx_ready = 1'b1;
                    if (accept) nxt = ST_OPC;
                end else begin
                    push_valid = rx_valid;
                    push_data  = reg_rdata;
                    rx_ready   = push_ready;
                    reg_re     = accept;
                end
            end
            ST_WREG: begin
                rx_ready = 1'b1;
                if (accept) nxt = is_end ? ST_OPC : ST_WVAL;
            end
            ST_WVAL: begin
                rx_ready = 1'b1;
                reg_we   = rx_valid;
                if (accept) nxt = ST_WREG;
            end
            ST_PVAL: begin
                rx_ready = 1'b1;
                if (accept) nxt = ST_PEND;
            end
            ST_PEND: begin
                rx_ready = 1'b1;
                pin_we   = rx_valid && is_end;
                if (accept) nxt = ST_OPC;
            end
            ST_IEND: begin
                if (is_end) begin
                    push_valid = rx_valid;
                    push_data  = pin_in;
                    rx_ready   = push_ready;
                end else begin
                    rx_ready = 1'b1;
                end
                if (accept) nxt = ST_OPC;
            end
            ST_KEY1: begin
                rx_ready = 1'b1;
                if (accept) nxt = (rx_data == KEY_A) ? ST_KEY2 : ST_OPC;
            end
            ST_KEY2: begin
                rx_ready = 1'b1;
                if (accept) nxt = (rx_data == KEY_B) ? ST_ZEND : ST_OPC;
            end
            ST_ZEND: begin
                rx_ready  = 1'b1;
                sleep_req = rx_valid && is_end;
                if (accept) nxt = ST_OPC;
            end
            default: nxt = ST_OPC;
        endcase
        if (expire && !accept) nxt = ST_OPC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HELLO0;
            hold  <= '0;
            left  <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                case (state)
                    ST_ADR, ST_WREG, ST_PVAL: hold <= rx_data;
                    ST_CNT:                   left <= rx_data;
                    ST_WDATA:                 left <= left - 8'd1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
    import cfp_pkg::*;
#(
    parameter int TXQ_DEPTH = 16,
    parameter int GAP_LIMIT = 4829000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       bus_req_valid,
    input  logic       bus_req_ready,
    output logic [1:0] bus_req_op,
    output logic [7:0] bus_req_arg,
    input  logic       bus_rd_valid,
    input  logic [7:0] bus_rd_data,
    output logic       bus_rd_ready,
    output logic       reg_we,
    output logic       reg_re,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata,
    output logic       pin_we,
    output logic [7:0] pin_wdata,
    input  logic [7:0] pin_in,
    output logic       sleep_req
);
    bus_req_t   req;
    logic       q_full, q_push, dec_push, dec_push_ready;
    logic [7:0] dec_pdata, q_pdata;
    logic       expire, active, accept;

    assign bus_req_op     = req.op;
    assign bus_req_arg    = req.arg;
    assign reg_wdata      = rx_data;
    assign bus_rd_ready   = !q_full;
    assign dec_push_ready = !q_full && !bus_rd_valid;
    assign q_push         = (bus_rd_valid || dec_push) && !q_full;
    assign q_pdata        = bus_rd_valid ? bus_rd_data : dec_pdata;

    cfp_decoder u_dec (
        .clk, .rst, .rx_valid, .rx_data, .rx_ready,
        .req_valid(bus_req_valid), .req, .req_ready(bus_req_ready),
        .reg_we, .reg_re, .reg_addr, .reg_rdata,
        .pin_we, .pin_wdata, .pin_in, .sleep_req,
        .push_valid(dec_push), .push_data(dec_pdata), .push_ready(dec_push_ready),
        .expire, .active, .accept
    );

    cfp_gap_timer #(.LIMIT(GAP_LIMIT)) u_gap (
        .clk, .rst, .active, .kick(accept), .expire
    );

    cfp_txq #(.DEPTH(TXQ_DEPTH), .W(8)) u_txq (
        .clk, .rst, .push(q_push), .pdata(q_pdata), .full(q_full),
        .pop(tx_ready), .qdata(tx_data), .nonempty(tx_valid)
    );
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       bus_req_valid,
    input logic       reg_we,
    input logic       reg_re,
    input logic       pin_we,
    input logic       sleep_req
);
    // R3
    bus_req_from_host_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> rx_valid);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_we, reg_re, pin_we, sleep_req, bus_req_valid}));

    // R7
    reg_we_accept_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (rx_valid && rx_ready));

    // R11
    sleep_on_term_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> (rx_valid && rx_ready && rx_data == 8'h50));

    // R11
    sleep_single_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> !sleep_req);

    // R13
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind cmd_frame_parser cfp_checker u_chk (.*);

// File: tb/sim_cmd_frame_parser.sv
module sim_cmd_frame_parser;
    logic       clk = 0;
    logic       rst = 1;
    logic       rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic       rx_ready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1;
    logic       bus_req_valid;
    logic       bus_req_ready = 1;
    logic [1:0] bus_req_op;
    logic [7:0] bus_req_arg;
    logic       bus_rd_valid = 0;
    logic [7:0] bus_rd_data = 0;
    logic       bus_rd_ready;
    logic       reg_we, reg_re;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       pin_we;
    logic [7:0] pin_wdata;
    logic [7:0] pin_in = 8'h3C;
    logic       sleep_req;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    logic [1:0] b_op  [256];
    logic [7:0] b_arg [256];
    logic [7:0] w_adr [256];
    logic [7:0] w_dat [256];
    logic [7:0] p_dat [256];
    logic [7:0] t_log [256];
    int nb = 0, nw = 0, np = 0, nt = 0, ns = 0, nr = 0;

    always #4 clk = ~clk;

    assign reg_rdata = reg_addr + 8'h30;

    cmd_frame_parser #(.TXQ_DEPTH(16), .GAP_LIMIT(64)) u0 (.*);

    always @(posedge clk) begin
        if (!rst) begin
            if (bus_req_valid && bus_req_ready) begin
                b_op[nb[7:0]] <= bus_req_op; b_arg[nb[7:0]] <= bus_req_arg; nb <= nb + 1;
            end
            if (reg_we) begin
                w_adr[nw[7:0]] <= reg_addr; w_dat[nw[7:0]] <= reg_wdata; nw <= nw + 1;
            end
            if (reg_re) nr <= nr + 1;
            if (pin_we) begin
                p_dat[np[7:0]] <= pin_wdata; np <= np + 1;
            end
            if (sleep_req) ns <= ns + 1;
            if (tx_valid && tx_ready) begin
                t_log[nt[7:0]] <= tx_data; nt <= nt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_give(input logic [7:0] b);
        bus_rd_data  = b;
        bus_rd_valid = 1;
        while (!bus_rd_ready) @(negedge clk);
        @(negedge clk);
        bus_rd_valid = 0;
    endtask

    task automatic t_reset;
        check(rx_ready == 0, "R1 rx_ready held during greeting", rx_ready, 0);
        idle(10);
        check(nt == 2, "R1 greeting length", nt, 2);
        check(t_log[0] == 8'h4F && t_log[1] == 8'h4B, "R1 greeting bytes",
              {t_log[0], t_log[1]}, 16'h4F4B);
    endtask

    task automatic t_unknown;
        int b0 = nb, w0 = nw, t0 = nt;
        send(8'h41); send(8'h00); send(8'h50);
        send(8'h49); send(8'h50);
        idle(5);
        check(nb == b0 && nw == w0, "R2 no action on unknown opcode", nb + nw, b0 + w0);
        check(nt == t0 + 1 && t_log[t0[7:0]] == 8'h3C, "R10 pin read after junk",
              t_log[t0[7:0]], 8'h3C);
    endtask

    task automatic t_bus_write;
        int b0 = nb;
        send(8'h53); send(8'h40); send(8'h02); send(8'h11); send(8'h22); send(8'h50);
        idle(3);
        check(nb == b0 + 4, "R3 request count", nb - b0, 4);
        check(b_op[b0[7:0]] == 0 && b_arg[b0[7:0]] == 8'h40, "R3 start",
              b_arg[b0[7:0]], 8'h40);
        check(b_op[b0[7:0]+1] == 1 && b_arg[b0[7:0]+1] == 8'h11 &&
              b_op[b0[7:0]+2] == 1 && b_arg[b0[7:0]+2] == 8'h22, "R3 data",
              {b_arg[b0[7:0]+1], b_arg[b0[7:0]+2]}, 16'h1122);
        check(b_op[b0[7:0]+3] == 3, "R3 stop", b_op[b0[7:0]+3], 3);
        b0 = nb;
        send(8'h53); send(8'h42); send(8'h00); send(8'h50);
        idle(3);
        check(nb == b0 + 2 && b_op[b0[7:0]+1] == 3, "R3 zero count", nb - b0, 2);
    endtask

    task automatic t_bus_read;
        int b0 = nb, t0 = nt;
        send(8'h53); send(8'h41); send(8'h03); send(8'h50);
        idle(3);
        check(nb == b0 + 3 && b_op[b0[7:0]] == 0 && b_op[b0[7:0]+1] == 2 &&
              b_arg[b0[7:0]+1] == 8'h03 && b_op[b0[7:0]+2] == 3, "R4 read frame",
              b_arg[b0[7:0]+1], 3);
        bus_give(8'hA1); bus_give(8'hB2); bus_give(8'hC3);
        idle(8);
        check(nt == t0 + 3 && t_log[t0[7:0]] == 8'hA1 && t_log[t0[7:0]+1] == 8'hB2 &&
              t_log[t0[7:0]+2] == 8'hC3, "R6 read data order", nt - t0, 3);
    endtask

    task automatic t_chain;
        int b0 = nb;
        send(8'h53); send(8'h40); send(8'h01); send(8'hAA);
        send(8'h77);
        send(8'h53); send(8'h41); send(8'h02); send(8'h50);
        idle(3);
        check(nb == b0 + 5, "R5 chained request count", nb - b0, 5);
        check(b_op[b0[7:0]+2] == 0 && b_arg[b0[7:0]+2] == 8'h41, "R5 repeated start",
              b_op[b0[7:0]+2], 0);
        check(b_op[b0[7:0]+3] == 2 && b_op[b0[7:0]+4] == 3, "R5 read then stop",
              b_op[b0[7:0]+3], 2);
    endtask

    task automatic t_regs;
        int w0 = nw, t0 = nt;
        send(8'h57); send(8'h01); send(8'h12); send(8'h02); send(8'h34); send(8'h50);
        idle(3);
        check(nw == w0 + 2 && w_adr[w0[7:0]] == 1 && w_dat[w0[7:0]] == 8'h12 &&
              w_adr[w0[7:0]+1] == 2 && w_dat[w0[7:0]+1] == 8'h34, "R7 register writes",
              nw - w0, 2);
        send(8'h52); send(8'h03); send(8'h05); send(8'h50);
        idle(6);
        check(nt == t0 + 2 && t_log[t0[7:0]] == 8'h33 && t_log[t0[7:0]+1] == 8'h35,
              "R8 register reads", {t_log[t0[7:0]], t_log[t0[7:0]+1]}, 16'h3335);
    endtask

    task automatic t_pins;
        int p0 = np, t0 = nt;
        send(8'h4F); send(8'h5C); send(8'h50);
        idle(2);
        check(np == p0 + 1 && p_dat[p0[7:0]] == 8'h5C, "R9 pin write", p_dat[p0[7:0]], 8'h5C);
        send(8'h4F); send(8'h11); send(8'h20);
        idle(2);
        check(np == p0 + 1, "R9 pin write aborted", np - p0, 1);
        pin_in = 8'h96;
        send(8'h49); send(8'h50);
        idle(5);
        check(nt == t0 + 1 && t_log[t0[7:0]] == 8'h96, "R10 pin read", t_log[t0[7:0]], 8'h96);
    endtask

    task automatic t_sleep;
        int s0 = ns;
        send(8'h5A); send(8'h5A); send(8'hA4); send(8'h50);
        idle(2);
        check(ns == s0, "R11 bad key", ns - s0, 0);
        send(8'h5A); send(8'h5A); send(8'hA5); send(8'h50);
        idle(2);
        check(ns == s0 + 1, "R11 good key", ns - s0, 1);
    endtask

    task automatic t_gap;
        int w0 = nw, t0 = nt;
        send(8'h57); send(8'h08); idle(40); send(8'h66); send(8'h50);
        idle(2);
        check(nw == w0 + 1 && w_dat[w0[7:0]] == 8'h66, "R12 short pause kept", nw - w0, 1);
        send(8'h57); send(8'h07); idle(100); send(8'h55);
        send(8'h49); send(8'h50);
        idle(5);
        check(nw == w0 + 1, "R12 timed-out write dropped", nw - w0, 1);
        check(nt == t0 + 1 && t_log[t0[7:0]] == pin_in, "R12 next byte is opcode",
              nt - t0, 1);
    endtask

    task automatic t_full;
        int t0 = nt;
        tx_ready = 0;
        send(8'h52);
        for (int i = 0; i < 16; i++) send(8'(i));
        rx_data  = 8'h10;
        rx_valid = 1;
        idle(3);
        check(rx_ready == 0, "R13 stall when queue full", rx_ready, 0);
        tx_ready = 1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 0;
        send(8'h50);
        idle(25);
        check(nt == t0 + 17 && t_log[t0[7:0]] == 8'h30 && t_log[t0[7:0]+16] == 8'h40,
              "R13 no byte lost", nt - t0, 17);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                total++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_unknown();
        t_bus_write();
        t_bus_read();
        t_chain();
        t_regs();
        t_pins();
        t_sleep();
        t_gap();
        t_full();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule